// File: doc/BRIEF.md
# Single-Bank Coprocessor Interrupt Controller

This block gathers up to 32 interrupt sources for a small management coprocessor and reduces them to one interrupt request line. Each source has one bit in each of four registers: a latched pending bit, an enable bit, a mask bit and a response bit. A source that is asserted while its enable bit is set latches its pending bit. The pending bit holds until software clears it by writing a one to it. The request to the coprocessor is raised while any pending bit is unmasked. There is no priority arbitration. Any set bit in the response register silences the request for every source.

Source 0 is always the non-maskable interrupt pin, after a trigger conditioner. The conditioner turns the pin into a request on a high level, a low level, a rising edge or a falling edge. Its pending bit keeps the event until software clears it, whatever trigger mode is in use. Sources 1 to 31 come straight from the request inputs, in the same order as the matching inputs of the main interrupt controller.

Software uses a simple synchronous register port. A write takes effect at the next clock edge. Read data is combinational from the address.

Top module: `mgmt_intc`

## Requirements
- R1: After reset, the enable, mask, response, pending and trigger-mode registers all read zero, and `irq_o` is low.
- R2: Enable (byte offset 0x04), mask (0x08) and response (0x0C) are 32-bit read/write registers. The trigger mode is read/write in bits [1:0] at offset 0x10, and its upper bits read zero. Unmapped or misaligned addresses read zero, and writes to them have no effect.
- R3: Pending bit i sets at the clock edge where source i is asserted and enable bit i is set. It stays set after the source drops. Offset 0x00 reads the latched pending bits.
- R4: A source whose enable bit is clear never sets its pending bit.
- R5: Writing to offset 0x00 clears each pending bit that is written with a one and leaves bits written with a zero unchanged. If a bit's source is asserted and enabled in the same cycle, the set wins.
- R6: While the response register is zero, `irq_o` is high exactly when some pending bit has its mask bit clear (mask bit 1 = masked).
- R7: While any response bit is set, `irq_o` is low for every source.
- R8: Source 0 is `nmi_i` after conditioning. Trigger mode 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge. An edge is measured against the pin value sampled at the previous clock edge, and the trigger mode that applies is the one held before the edge.
- R9: `src_i[k]` drives pending bit k for k = 1..NUM_SRC-1, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable interrupt pin, before conditioning |
| src_i | input | NUM_SRC-1 | Request lines for sources 1..NUM_SRC-1 |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the coprocessor |

## Verification
The bench builds the block with its defaults: NUM_SRC = 32 and ADDR_W = 5. The full 32-bit width brings the top source bit and whole-word response blocking within reach. The 5-bit address takes in all five mapped offsets, the unmapped words 0x14 to 0x1C and misaligned addresses. Random register traffic runs against a bench model and is mixed with directed sequences for each trigger mode, for a clear and a set in the same cycle, and for the source order.

// File: rtl/mgmt_intc_pkg.sv
package mgmt_intc_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // register select codes, equal to word index of the byte offset
  localparam logic [2:0] SEL_PEND = 3'd0;
  localparam logic [2:0] SEL_EN   = 3'd1;
  localparam logic [2:0] SEL_MASK = 3'd2;
  localparam logic [2:0] SEL_RESP = 3'd3;
  localparam logic [2:0] SEL_TRIG = 3'd4;
  localparam logic [2:0] SEL_NONE = 3'd7;
  localparam int unsigned NUM_WORDS = 5;
endpackage

// File: rtl/mgmt_intc_nmi_cond.sv
module mgmt_intc_nmi_cond
  import mgmt_intc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  nmi_i,
  input  trig_e trig_i,
  output logic  evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= nmi_i;
  end

  always_comb begin
    unique case (trig_i)
      TRIG_HIGH: evt_o = nmi_i;
      TRIG_LOW:  evt_o = !nmi_i;
      TRIG_RISE: evt_o = nmi_i && !prev_q;
      TRIG_FALL: evt_o = !nmi_i && prev_q;
      default:   evt_o = 1'b0;
    endcase
  end

  // R8
  rise_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == TRIG_RISE && $rose(nmi_i)) |-> evt_o);
  // R8
  fall_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == TRIG_FALL && evt_o) |-> !nmi_i);
endmodule

// File: rtl/mgmt_intc_cfg.sv
module mgmt_intc_cfg
  import mgmt_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         sel_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] resp_o,
  output trig_e              trig_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [NUM_SRC-1:0] wval;
  assign wval = wdata_i[NUM_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      mask_o <= '0;
      resp_o <= '0;
      trig_o <= TRIG_HIGH;
    end else if (we_i) begin
      if (sel_i == SEL_EN)   en_o   <= wval;
      if (sel_i == SEL_MASK) mask_o <= wval;
      if (sel_i == SEL_RESP) resp_o <= wval;
      if (sel_i == SEL_TRIG) trig_o <= trig_e'(wdata_i[1:0]);
    end
  end

  // write-one-to-clear strobe for the pending bank
  assign clr_o = (we_i && sel_i == SEL_PEND) ? wval : '0;

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o) && $stable(mask_o) && $stable(resp_o));
endmodule

// File: rtl/mgmt_intc_pend.sv
module mgmt_intc_pend #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= 1'b0;
      else if (req_i[i] && en_i[i]) q <= 1'b1;   // set wins over clear
      else if (clr_i[i])          q <= 1'b0;
    end
    assign pend_o[i] = q;
  end

  // R4
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(req_i & en_i)) == '0));
  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_o) & ~$past(clr_i) & ~pend_o) == '0));
  // R5
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~(req_i & en_i)) != '0) |=>
      ((pend_o & $past(clr_i & ~(req_i & en_i))) == '0));
endmodule

// File: rtl/mgmt_intc.sv
module mgmt_intc
  import mgmt_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [NUM_SRC-1:1] src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned WI_W = ADDR_W - 2;

  logic [WI_W-1:0]    word_idx;
  logic               acc_hit;
  logic [2:0]         sel;
  logic [NUM_SRC-1:0] en, mask, resp, clr, pend, req;
  trig_e              trig;
  logic               nmi_evt;

  assign word_idx = reg_addr_i[ADDR_W-1:2];
  assign acc_hit  = (reg_addr_i[1:0] == 2'b00) && (word_idx < WI_W'(NUM_WORDS));
  assign sel      = acc_hit ? word_idx[2:0] : SEL_NONE;

  mgmt_intc_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en),
    .mask_o  (mask),
    .resp_o  (resp),
    .trig_o  (trig),
    .clr_o   (clr)
  );

  mgmt_intc_nmi_cond u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .trig_i (trig),
    .evt_o  (nmi_evt)
  );

  assign req = {src_i, nmi_evt};

  mgmt_intc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .en_i   (en),
    .clr_i  (clr),
    .pend_o (pend)
  );

  // no priority: any response bit blocks the whole request
  assign irq_o = (resp == '0) && ((pend & ~mask) != '0);

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_PEND: reg_rdata_o[NUM_SRC-1:0] = pend;
      SEL_EN:   reg_rdata_o[NUM_SRC-1:0] = en;
      SEL_MASK: reg_rdata_o[NUM_SRC-1:0] = mask;
      SEL_RESP: reg_rdata_o[NUM_SRC-1:0] = resp;
      SEL_TRIG: reg_rdata_o[1:0]         = trig;
      default:  reg_rdata_o              = '0;
    endcase
  end

  // R7
  resp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp != '0) |-> !irq_o);
  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend & ~mask) != '0));
endmodule

// File: tb/mgmt_intc_test.sv
`timescale 1ns/1ps
module mgmt_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 1'b0;
  logic [31:1] src = '0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_en, m_msk, m_rsp, m_pend;
  logic [1:0]  m_trig;
  logic        m_prev;

  always #2.5 clk = ~clk;

  mgmt_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .src_i(src),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic cond_nmi(logic [1:0] t, logic n, logic p);
    case (t)
      2'd0: return n;
      2'd1: return !n;
      2'd2: return n && !p;
      default: return !n && p;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd0: return m_pend;
      3'd1: return m_en;
      3'd2: return m_msk;
      3'd3: return m_rsp;
      3'd4: return {30'd0, m_trig};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_rsp == '0) && ((m_pend & ~m_msk) != '0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_msk = '0; m_rsp = '0; m_pend = '0; m_trig = '0; m_prev = 1'b0;
  endtask

  // one clock: drive at negedge, check comb outputs, then advance the model at posedge
  task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d,
                      input logic n, input logic [31:1] s);
    logic [31:0] clr;
    logic [31:0] reqv;
    @(negedge clk);
    we = w; addr = a; wdata = d; nmi = n; src = s;
    #1;
    chk(rdata == exp_read(a), (a[4:2] == 3'd0) ? "R3 read" : "R2 read", rdata, exp_read(a));
    chk(irq == exp_irq(), (m_rsp != 0) ? "R7 irq" : "R6 irq", {31'd0, irq}, {31'd0, exp_irq()});
    @(posedge clk);
    clr  = (w && a == 5'h00) ? d : '0;
    reqv = {s, cond_nmi(m_trig, n, m_prev)};
    m_pend = (m_pend & ~clr) | (reqv & m_en);
    if (w && a == 5'h04) m_en  = d;
    if (w && a == 5'h08) m_msk = d;
    if (w && a == 5'h0C) m_rsp = d;
    if (w && a == 5'h10) m_trig = d[1:0];
    m_prev = n;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk(rdata == e, tag, rdata, e);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    @(negedge clk);
    we = 1'b0;
    #1;
    chk(irq == e, tag, {31'd0, irq}, {31'd0, e});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(irq == 1'b0, "R1 irq in reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(5'h00, 32'd0, "R1 pend");
    rd_chk(5'h04, 32'd0, "R1 en");
    rd_chk(5'h08, 32'd0, "R1 mask");
    rd_chk(5'h0C, 32'd0, "R1 resp");
    rd_chk(5'h10, 32'd0, "R1 trig");
    irq_chk(1'b0, "R1 irq");

    // R2 register readback and unmapped space
    step(1, 5'h04, 32'hFFFF_FFFF, 0, '0);
    step(1, 5'h08, 32'hA5A5_A5A5, 0, '0);
    step(1, 5'h10, 32'hFFFF_FFFF, 0, '0);
    step(1, 5'h14, 32'hFFFF_FFFF, 0, '0);
    step(1, 5'h05, 32'hFFFF_FFFF, 0, '0);
    rd_chk(5'h04, 32'hFFFF_FFFF, "R2 en");
    rd_chk(5'h08, 32'hA5A5_A5A5, "R2 mask");
    rd_chk(5'h10, 32'h0000_0003, "R2 trig");
    rd_chk(5'h14, 32'd0, "R2 unmapped");
    rd_chk(5'h05, 32'd0, "R2 misaligned");
    rd_chk(5'h0C, 32'd0, "R2 resp untouched");
    step(1, 5'h10, 32'h0, 0, '0);

    // R9 top source maps to bit 31; masked, then unmasked; R7 blocking
    step(0, 5'h00, 0, 0, 31'h4000_0000);
    step(0, 5'h00, 0, 0, '0);
    rd_chk(5'h00, 32'h8000_0000, "R9 bit31");
    irq_chk(1'b0, "R6 masked");
    step(1, 5'h08, 32'h0, 0, '0);
    irq_chk(1'b1, "R6 unmasked");
    step(1, 5'h0C, 32'h0000_0200, 0, '0);
    irq_chk(1'b0, "R7 resp blocks");
    step(1, 5'h0C, 32'h0, 0, '0);
    irq_chk(1'b1, "R7 resp released");

    // R5 selective clear and set-wins
    step(0, 5'h00, 0, 0, 31'h0000_0008);
    step(1, 5'h00, 32'h0000_0010, 0, '0);
    rd_chk(5'h00, 32'h8000_0000, "R5 selective clear");
    step(1, 5'h00, 32'h8000_0000, 0, 31'h4000_0000);
    rd_chk(5'h00, 32'h8000_0000, "R5 set wins");
    step(1, 5'h00, 32'hFFFF_FFFF, 0, '0);
    rd_chk(5'h00, 32'h0, "R5 cleared");
    irq_chk(1'b0, "R6 nothing pending");

    // R4 disabled sources ignored
    step(1, 5'h04, 32'h0000_0004, 0, '0);
    step(0, 5'h00, 0, 1, 31'h7FFF_FFFF);
    step(0, 5'h00, 0, 0, '0);
    rd_chk(5'h00, 32'h0000_0004, "R4 only enabled bit");
    step(1, 5'h00, 32'hFFFF_FFFF, 0, '0);

    // R8 trigger modes on source 0
    step(1, 5'h04, 32'h0000_0001, 0, '0);
    step(1, 5'h10, 32'd2, 1, '0);          // pin high, mode still level-high
    step(1, 5'h00, 32'h1, 1, '0);          // clear; rise mode now, pin held
    step(0, 5'h00, 0, 1, '0);
    rd_chk(5'h00, 32'h0, "R8 rise no edge");
    step(0, 5'h00, 0, 0, '0);
    step(0, 5'h00, 0, 1, '0);
    rd_chk(5'h00, 32'h1, "R8 rise edge");
    step(1, 5'h10, 32'd3, 1, '0);
    step(1, 5'h00, 32'h1, 1, '0);
    step(0, 5'h00, 0, 0, '0);
    rd_chk(5'h00, 32'h1, "R8 fall edge");
    step(1, 5'h10, 32'd1, 1, '0);
    step(1, 5'h00, 32'h1, 1, '0);
    rd_chk(5'h00, 32'h0, "R8 low mode pin high");
    step(0, 5'h00, 0, 0, '0);
    rd_chk(5'h00, 32'h1, "R8 low mode pin low");
    step(1, 5'h00, 32'h1, 1, '0);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic        w;
      logic [2:0]  wd_idx;
      logic [31:0] d;
      w = ($urandom % 4) == 0;
      wd_idx = 3'($urandom % 7);
      d = $urandom;
      if (wd_idx == 3'd3 && ($urandom % 4) != 0) d = '0;
      else if (wd_idx == 3'd3) d = 32'd1 << ($urandom % 32);
      step(w, {wd_idx, 2'b00}, d, 1'($urandom), 31'($urandom & $urandom & $urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule